// File: doc/BRIEF.md
# Four-Phase Accumulator Processor Core

This is a small processor core with an 8-bit data path. It has two working registers, A and B, a holding register T, a 4-bit arithmetic/logic unit and a 7-bit program counter. It also has a 16-byte scratch RAM that takes its address from B, one 8-bit input port and one 8-bit output port. Instructions are one byte each. The core fetches them from a 128-byte program store outside the core, through an address output and a data input with a combinational read.

There are three kinds of instruction: load an immediate value into A, move a byte from a source to a destination, and an ALU operation whose result goes to A. Each instruction runs in four clock cycles:

1. Fetch into the instruction register.
2. Capture the source value in T.
3. Let T drive the internal bus.
4. Write the destination and advance or load the program counter.

Because every value passes through T, A is never written from a path that depends on A's own output. A move into the program counter is a jump. The jump is skipped when B holds 0x0F, which gives a simple conditional branch.

Top module: `tacc_core`

## Requirements
- R1: An instruction with bit 7 set loads A with zero in bit 7 and instruction bits 6..0 below it.
- R2: An instruction with bit 7 clear and bit 6 set is a move. It takes its source code from bits 5..3 and its destination code from bits 2..0. The source codes are 0=A, 1=B, 2=input port, 3=RAM. The destination codes are 0=A, 1=B, 2=PC, 3=RAM, 4=output port.
- R3: RAM holds 16 bytes. Reads and writes use B bits 3..0 as the address.
- R4: A move to PC loads PC from bits 6..0 of the moved byte, and the next fetch comes from that address.
- R5: When B equals 0x0F, a move to PC changes nothing except the normal PC increment.
- R6: An instruction with bits 7 and 6 both clear is an ALU operation on the low nibbles of A and B. Bit 4 is the mode (1=logic) and bits 3..0 select the function. The result is zero-extended into A. The functions include: logic 4 = NAND and logic 6 = XOR; arithmetic 9 = A+B and arithmetic 6 = A-B-1.
- R7: Each instruction takes exactly four clock cycles. PC, A, B, RAM and the output port change only on the fourth edge. PC wraps from 127 to 0.
- R8: Source codes 4 to 7 deliver zero. Destination codes 5 to 7 write nothing.
- R9: An active-low asynchronous reset clears PC, A, B, T, the output port and the phase counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_data_i | input | 8 | Instruction byte at imem_addr_o |
| imem_addr_o | output | 7 | Program counter, used as the fetch address |
| in_port_i | input | 8 | Input port |
| out_port_o | output | 8 | Output port register |

## Verification
The jump load and the regular PC increment are both decided on the fourth edge. The bench provokes them together in two ways. First, it runs a move to PC while B is 0x0F, then the same move with B set to 1. It judges both from the fetch address after the instruction completes. Second, it jumps to address 127 and executes there, so the increment must wrap to 0 rather than carry. A move of A into B is also followed by a RAM access, to show that the RAM pointer is the value B had when the access ran.

// File: rtl/tacc_pkg.sv
package tacc_pkg;
  localparam logic [1:0] PH_FETCH = 2'd0;
  localparam logic [1:0] PH_GRAB  = 2'd1;
  localparam logic [1:0] PH_DRIVE = 2'd2;
  localparam logic [1:0] PH_STORE = 2'd3;

  localparam logic [2:0] SRC_A   = 3'd0;
  localparam logic [2:0] SRC_B   = 3'd1;
  localparam logic [2:0] SRC_IN  = 3'd2;
  localparam logic [2:0] SRC_RAM = 3'd3;

  localparam logic [2:0] DST_A   = 3'd0;
  localparam logic [2:0] DST_B   = 3'd1;
  localparam logic [2:0] DST_PC  = 3'd2;
  localparam logic [2:0] DST_RAM = 3'd3;
  localparam logic [2:0] DST_OUT = 3'd4;
endpackage

// File: rtl/tacc_phase.sv
module tacc_phase (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [1:0] phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= 2'd0;
    else         phase_o <= phase_o + 2'd1;
  end

  p_phase_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_o == $past(phase_o) + 2'd1);
endmodule

// File: rtl/tacc_alu.sv
module tacc_alu #(
  parameter int NW = 4
) (
  input  logic [NW-1:0] a_i,
  input  logic [NW-1:0] b_i,
  input  logic          logic_i,
  input  logic [3:0]    sel_i,
  output logic [NW-1:0] f_o
);
  logic [NW-1:0] nb, one;
  assign nb  = ~b_i;
  assign one = NW'(1);

  always_comb begin
    if (logic_i) begin
      case (sel_i)
        4'h0: f_o = ~a_i;
        4'h1: f_o = ~(a_i | b_i);
        4'h2: f_o = ~a_i & b_i;
        4'h3: f_o = '0;
        4'h4: f_o = ~(a_i & b_i);
        4'h5: f_o = nb;
        4'h6: f_o = a_i ^ b_i;
        4'h7: f_o = a_i & nb;
        4'h8: f_o = ~a_i | b_i;
        4'h9: f_o = ~(a_i ^ b_i);
        4'hA: f_o = b_i;
        4'hB: f_o = a_i & b_i;
        4'hC: f_o = '1;
        4'hD: f_o = a_i | nb;
        4'hE: f_o = a_i | b_i;
        default: f_o = a_i;
      endcase
    end else begin
      case (sel_i)
        4'h0: f_o = a_i;
        4'h1: f_o = a_i | b_i;
        4'h2: f_o = a_i | nb;
        4'h3: f_o = '1;
        4'h4: f_o = a_i + (a_i & nb);
        4'h5: f_o = (a_i | b_i) + (a_i & nb);
        4'h6: f_o = a_i - b_i - one;
        4'h7: f_o = (a_i & nb) - one;
        4'h8: f_o = a_i + (a_i & b_i);
        4'h9: f_o = a_i + b_i;
        4'hA: f_o = (a_i | nb) + (a_i & b_i);
        4'hB: f_o = (a_i & b_i) - one;
        4'hC: f_o = a_i + a_i;
        4'hD: f_o = (a_i | b_i) + a_i;
        4'hE: f_o = (a_i | nb) + a_i;
        default: f_o = a_i - one;
      endcase
    end
  end
endmodule

// File: rtl/tacc_ram.sv
module tacc_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/tacc_core.sv
module tacc_core
  import tacc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PCW    = 7,
  parameter int NW     = 4,
  parameter int RAM_AW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  imem_data_i,
  output logic [PCW-1:0] imem_addr_o,
  input  logic [DW-1:0]  in_port_i,
  output logic [DW-1:0]  out_port_o
);
  localparam int IMM_W = DW - 1;
  localparam logic [DW-1:0] NOJUMP_KEY = DW'(15);

  logic [1:0]       phase;
  logic [DW-1:0]    ir_q, a_q, b_q, t_q, out_q;
  logic [PCW-1:0]   pc_q;
  logic [DW-1:0]    src_data, grab_data, ram_rdata;
  logic [NW-1:0]    alu_f;
  logic             is_ldi, is_mov, is_alu, store;
  logic [2:0]       src_sel, dst_sel;
  logic             wr_a, wr_b, wr_out, ram_we, jump_take;

  tacc_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase)
  );

  assign is_ldi  = ir_q[DW-1];
  assign is_mov  = !ir_q[DW-1] && ir_q[DW-2];
  assign is_alu  = !ir_q[DW-1] && !ir_q[DW-2];
  assign src_sel = ir_q[5:3];
  assign dst_sel = ir_q[2:0];
  assign store   = (phase == PH_STORE);

  tacc_alu #(.NW(NW)) u_alu (
    .a_i    (a_q[NW-1:0]),
    .b_i    (b_q[NW-1:0]),
    .logic_i(ir_q[4]),
    .sel_i  (ir_q[3:0]),
    .f_o    (alu_f)
  );

  tacc_ram #(.DW(DW), .AW(RAM_AW)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .addr_i (b_q[RAM_AW-1:0]),
    .wdata_i(t_q),
    .rdata_o(ram_rdata)
  );

  always_comb begin
    case (src_sel)
      SRC_A:   src_data = a_q;
      SRC_B:   src_data = b_q;
      SRC_IN:  src_data = in_port_i;
      SRC_RAM: src_data = ram_rdata;
      default: src_data = '0;
    endcase
  end

  always_comb begin
    if (is_ldi)      grab_data = {1'b0, ir_q[IMM_W-1:0]};
    else if (is_alu) grab_data = {{(DW-NW){1'b0}}, alu_f};
    else             grab_data = src_data;
  end

  assign wr_a      = store && (is_ldi || is_alu || (is_mov && dst_sel == DST_A));
  assign wr_b      = store && is_mov && dst_sel == DST_B;
  assign wr_out    = store && is_mov && dst_sel == DST_OUT;
  assign ram_we    = store && is_mov && dst_sel == DST_RAM;
  assign jump_take = store && is_mov && dst_sel == DST_PC && b_q != NOJUMP_KEY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      t_q   <= '0;
      out_q <= '0;
      pc_q  <= '0;
    end else begin
      if (phase == PH_FETCH) ir_q <= imem_data_i;
      if (phase == PH_GRAB)  t_q  <= grab_data;
      if (wr_a)   a_q   <= t_q;
      if (wr_b)   b_q   <= t_q;
      if (wr_out) out_q <= t_q;
      if (store)  pc_q  <= jump_take ? t_q[PCW-1:0] : pc_q + PCW'(1);
    end
  end

  assign imem_addr_o = pc_q;
  assign out_port_o  = out_q;

  p_pc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_STORE) |=> $stable(pc_q));

  p_out_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_STORE) |=> $stable(out_q));

  p_jump_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store && is_mov && dst_sel == DST_PC && b_q == NOJUMP_KEY)
    |=> pc_q == $past(pc_q) + PCW'(1));

  p_imm_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store && is_ldi) |=> a_q == {1'b0, $past(ir_q[IMM_W-1:0])});

  p_b_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_STORE) |=> $stable(b_q));
endmodule

// File: tb/sim_tacc_core.sv
module sim_tacc_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] imem_data;
  logic [6:0] imem_addr;
  logic [7:0] in_port = 8'h5A;
  logic [7:0] out_port;
  logic [7:0] rom [128];
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign imem_data = rom[imem_addr];

  tacc_core u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .imem_data_i(imem_data),
    .imem_addr_o(imem_addr),
    .in_port_i  (in_port),
    .out_port_o (out_port)
  );

  // {addr, instruction, expected out after, expected pc after}
  localparam int NV = 29;
  localparam logic [29:0] VEC [NV] = '{
    {7'h00, 8'h83, 8'h00, 7'h01},  // A=3
    {7'h01, 8'h41, 8'h00, 7'h02},  // B=A
    {7'h02, 8'h86, 8'h00, 7'h03},  // A=6
    {7'h03, 8'h14, 8'h00, 7'h04},  // NAND -> 0D
    {7'h04, 8'h44, 8'h0D, 7'h05},
    {7'h05, 8'h86, 8'h0D, 7'h06},
    {7'h06, 8'h09, 8'h0D, 7'h07},  // A+B -> 9
    {7'h07, 8'h44, 8'h09, 7'h08},
    {7'h08, 8'h86, 8'h09, 7'h09},
    {7'h09, 8'h06, 8'h09, 7'h0A},  // A-B-1 -> 2
    {7'h0A, 8'h44, 8'h02, 7'h0B},
    {7'h0B, 8'h50, 8'h02, 7'h0C},  // A=in
    {7'h0C, 8'h43, 8'h02, 7'h0D},  // ram[3]=A
    {7'h0D, 8'h80, 8'h02, 7'h0E},  // A=0
    {7'h0E, 8'h5C, 8'h5A, 7'h0F},  // out=ram[3]
    {7'h0F, 8'h8F, 8'h5A, 7'h10},
    {7'h10, 8'h41, 8'h5A, 7'h11},  // B=0F
    {7'h11, 8'hB0, 8'h5A, 7'h12},
    {7'h12, 8'h42, 8'h5A, 7'h13},  // blocked jump
    {7'h13, 8'h81, 8'h5A, 7'h14},
    {7'h14, 8'h41, 8'h5A, 7'h15},  // B=1
    {7'h15, 8'hC0, 8'h5A, 7'h16},
    {7'h16, 8'h42, 8'h5A, 7'h40},  // jump 0x40
    {7'h40, 8'h4C, 8'h01, 7'h41},  // out=B
    {7'h41, 8'h47, 8'h01, 7'h42},  // unused dst
    {7'h42, 8'h6C, 8'h00, 7'h43},  // unused src -> 0
    {7'h43, 8'hFF, 8'h00, 7'h44},  // A=7F
    {7'h44, 8'h42, 8'h00, 7'h7F},  // jump 0x7F
    {7'h7F, 8'h44, 8'h7F, 7'h00}   // wrap
  };

  function automatic string tag_of(input logic [7:0] ins);
    if (ins[7])                     return "R1 load-immediate";
    if (!ins[6])                    return "R6 alu";
    if (ins[2:0] == 3'd2)           return "R4/R5 jump";
    if (ins[2:0] == 3'd3 || ins[5:3] == 3'd3) return "R3 ram";
    if (ins[2:0] > 3'd4 || ins[5:3] > 3'd3)   return "R8 unused code";
    return "R2 move";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step_instr();
    repeat (4) @(posedge clk);
    #2;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) rom[i] = 8'h00;
    for (int i = 0; i < NV; i++) rom[VEC[i][29:23]] = VEC[i][22:15];
    #2;
    chk("R9 reset pc", int'(imem_addr), 0);
    chk("R9 reset out", int'(out_port), 0);
    #10 rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step_instr();
      chk({tag_of(VEC[i][22:15]), " out"}, int'(out_port), int'(VEC[i][14:7]));
      chk({tag_of(VEC[i][22:15]), " pc"}, int'(imem_addr), int'(VEC[i][6:0]));
    end

    // reset clears A and B, then timing of a single move
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 reset out", int'(out_port), 0);
    chk("R9 reset pc", int'(imem_addr), 0);
    rom[0] = 8'h44;
    rom[1] = 8'h4C;
    rom[2] = 8'h54;
    rom[3] = 8'hC4;
    in_port = 8'hA5;
    @(negedge clk);
    rst_n = 1'b1;
    step_instr();
    chk("R9 A cleared", int'(out_port), 0);
    step_instr();
    chk("R9 B cleared", int'(out_port), 0);
    repeat (3) @(posedge clk);
    #2;
    chk("R7 out before fourth edge", int'(out_port), 0);
    chk("R7 pc before fourth edge", int'(imem_addr), 2);
    @(posedge clk);
    #2;
    chk("R2 in to out", int'(out_port), 8'hA5);
    chk("R7 pc after fourth edge", int'(imem_addr), 3);
    repeat (2) @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R9 mid-instruction reset pc", int'(imem_addr), 0);
    chk("R9 mid-instruction reset out", int'(out_port), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule